// File: doc/BRIEF.md
# Condition Code and Branch Evaluator

This block keeps the three result-sign flags of a 16-bit register machine and decides whether a conditional branch goes. When the register file accepts a write, the block classifies the written two's-complement value as negative, zero or positive. The write must come from an instruction class that is allowed to update the flags. The block stores that class as a one-hot flag register. Exactly one flag is set at all times.

A branch instruction has a three-bit condition mask. The block compares that mask against the stored flags and raises a taken signal when the two overlap. The flags are also presented as the low field of a 16-bit processor status word, so that a context-save path can capture them.

Top module: `cc_branch_eval`

## Requirements
- R1: After reset the flag register reads Z only (`flags` = 3'b010, with bit 2 = N, bit 1 = Z, bit 0 = P).
- R2: After a qualifying write, the flags change on the next rising clock edge. A value with bit 15 set gives N (3'b100), the all-zero value gives Z (3'b010), and any other value gives P (3'b001).
- R3: `flags` has exactly one bit set on every cycle after reset.
- R4: The flags update only when `wr_en` is high and `op_class` is one of the flag-writing classes: ARITH=3'd1, LOAD=3'd2, LEA=3'd3. The classes NONE=0, STORE=4, BRANCH=5, JUMP=6 and TRAP=7 leave the flags unchanged, even when `wr_en` is high.
- R5: `br_taken` is high when `instr[15:12]` is 4'b0000 and (`instr[11]` & N) | (`instr[10]` & Z) | (`instr[9]` & P). The signal is combinational from `instr` and the current flags.
- R6: `br_taken` is low whenever `instr[15:12]` is not 4'b0000, whatever the mask bits hold.
- R7: A mask of 3'b000 never branches, and a mask of 3'b111 always branches when the opcode is 0000.
- R8: `psw` carries the flags in bits [2:0] (bit 2 = N, bit 1 = Z, bit 0 = P). Bits [15:3] are zero.
- R9: The offset bits `instr[8:0]` have no effect on `br_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register-file write strobe |
| op_class | input | 3 | Decoded instruction class of the writing instruction |
| wr_data | input | 16 | Value being written to the register file |
| instr | input | 16 | Current instruction register |
| flags | output | 3 | One-hot flags {N,Z,P} |
| br_taken | output | 1 | Branch decision |
| psw | output | 16 | Status word with the flags in [2:0] |

## Verification
On every cycle, the assertions check three things: the one-hot flag invariant, that the flags hold when no qualifying write occurs, and that a branch is suppressed for non-branch opcodes. They also check the sign mapping of each accepted write one cycle later. The bench scenarios exercise the remaining behaviour:
- the reset value;
- the boundary values 0x8000, 0x7FFF, 0x0001 and 0xFFFF;
- every mask against every flag state;
- the extreme masks 000 and 111;
- the insensitivity of the decision to the offset field.

// File: rtl/cc_pkg.sv
package cc_pkg;
   localparam int unsigned NFLAG = 3;
   localparam int unsigned OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OPC_NONE   = 3'd0,
      OPC_ARITH  = 3'd1,
      OPC_LOAD   = 3'd2,
      OPC_LEA    = 3'd3,
      OPC_STORE  = 3'd4,
      OPC_BRANCH = 3'd5,
      OPC_JUMP   = 3'd6,
      OPC_TRAP   = 3'd7
   } op_class_e;

   localparam logic [NFLAG-1:0] FLG_N = 3'b100;
   localparam logic [NFLAG-1:0] FLG_Z = 3'b010;
   localparam logic [NFLAG-1:0] FLG_P = 3'b001;
endpackage

// File: rtl/cc_sign_class.sv
module cc_sign_class
   import cc_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] value,
   output logic [NFLAG-1:0]  cls
);
   localparam int unsigned MSB = DATA_W - 1;

   initial begin
      if (DATA_W < 2) $error("cc_sign_class: DATA_W must be at least 2");
   end

   logic is_zero;
   assign is_zero = (value == '0);

   always_comb begin
      if (value[MSB])   cls = FLG_N;
      else if (is_zero) cls = FLG_Z;
      else              cls = FLG_P;
   end

   always_comb begin
      AST_CLASS_ONEHOT: assert ($onehot(cls)); // R3
   end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
   import cc_pkg::*;
#(
   parameter logic [NFLAG-1:0] RESET_FLAGS = FLG_Z
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [NFLAG-1:0] nxt,
   output logic [NFLAG-1:0] q
);
   initial begin
      if ($countones(RESET_FLAGS) != 1) $error("cc_flag_reg: reset value must be one-hot");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= RESET_FLAGS;
      else if (upd) q <= nxt;
   end

   AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(q)); // R3
   AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(q)); // R4
   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> q == $past(nxt)); // R2
endmodule

// File: rtl/cc_branch_cmp.sv
module cc_branch_cmp
   import cc_pkg::*;
#(
   parameter int unsigned INSTR_W  = 16,
   parameter int unsigned OPC_BITS = 4,
   parameter logic [OPC_BITS-1:0] BR_OPC = '0,
   parameter bit          REGISTERED_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr,
   input  logic [NFLAG-1:0]   flags,
   output logic               taken
);
   localparam int unsigned OPC_LSB  = INSTR_W - OPC_BITS;
   localparam int unsigned MASK_LSB = OPC_LSB - NFLAG;

   initial begin
      if (INSTR_W < OPC_BITS + NFLAG) $error("cc_branch_cmp: instruction too narrow");
   end

   logic                is_br;
   logic [NFLAG-1:0]    mask;
   logic [NFLAG-1:0]    hit;
   logic                raw;

   assign is_br = (instr[INSTR_W-1:OPC_LSB] == BR_OPC);
   assign mask  = instr[OPC_LSB-1:MASK_LSB];

   for (genvar g = 0; g < NFLAG; g++) begin : g_hit
      assign hit[g] = mask[g] & flags[g];
   end

   assign raw = is_br & (|hit);

   generate
      if (REGISTERED_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) taken <= 1'b0;
            else        taken <= raw;
         end
      end else begin : g_comb
         assign taken = raw;
         always_comb begin
            if (!is_br) AST_NO_BR_NON_OPC: assert (!taken); // R6
            if (is_br && mask == '1 && $onehot(flags)) AST_ALWAYS_111: assert (taken); // R7
            if (mask == '0) AST_NEVER_000: assert (!taken); // R7
         end
      end
   endgenerate
endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
   import cc_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned PSW_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [OPC_W-1:0]   op_class,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [INSTR_W-1:0] instr,
   output logic [NFLAG-1:0]   flags,
   output logic               br_taken,
   output logic [PSW_W-1:0]   psw
);
   initial begin
      if (PSW_W < NFLAG) $error("cc_branch_eval: PSW too narrow");
   end

   logic             writes_reg;
   logic             upd;
   logic [NFLAG-1:0] cls;

   always_comb begin
      unique case (op_class_e'(op_class))
         OPC_ARITH, OPC_LOAD, OPC_LEA: writes_reg = 1'b1;
         default:                      writes_reg = 1'b0;
      endcase
   end

   assign upd = wr_en & writes_reg;

   cc_sign_class #(.DATA_W(DATA_W)) u_cls (
      .value (wr_data),
      .cls   (cls)
   );

   cc_flag_reg #(.RESET_FLAGS(FLG_Z)) u_flg (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (upd),
      .nxt   (cls),
      .q     (flags)
   );

   cc_branch_cmp #(.INSTR_W(INSTR_W), .OPC_BITS(4), .BR_OPC(4'b0000), .REGISTERED_OUT(1'b0)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .instr (instr),
      .flags (flags),
      .taken (br_taken)
   );

   assign psw = {{(PSW_W-NFLAG){1'b0}}, flags};

   AST_NONWRITER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(op_class inside {3'd1, 3'd2, 3'd3})) |=> $stable(flags)); // R4
   AST_NEG_SETS_N: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && wr_data[DATA_W-1]) |=> flags == FLG_N); // R2
   AST_PSW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      psw[PSW_W-1:NFLAG] == '0); // R8
endmodule

// File: tb/cc_branch_eval_tb.sv
module cc_branch_eval_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  op_class = 3'd0;
   logic [15:0] wr_data = 16'h0;
   logic [15:0] instr = 16'hF000;
   logic [2:0]  flags;
   logic        br_taken;
   logic [15:0] psw;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   cc_branch_eval u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_class(op_class),
      .wr_data(wr_data), .instr(instr), .flags(flags),
      .br_taken(br_taken), .psw(psw)
   );

   // {wr_data, op_class, expected flags after write}
   localparam int NV = 10;
   localparam logic [21:0] VEC [NV] = '{
      {16'h8000, 3'd1, 3'b100},
      {16'h7FFF, 3'd2, 3'b001},
      {16'h0000, 3'd3, 3'b010},
      {16'hFFFF, 3'd1, 3'b100},
      {16'h0001, 3'd1, 3'b001},
      {16'h0000, 3'd4, 3'b001},
      {16'h8000, 3'd5, 3'b001},
      {16'h0000, 3'd6, 3'b001},
      {16'hFFFF, 3'd7, 3'b001},
      {16'h1234, 3'd0, 3'b001}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d, input logic [2:0] oc);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; op_class = oc;
      @(negedge clk);
      wr_en = 1'b0; op_class = 3'd0;
   endtask

   function automatic logic model_br(input logic [15:0] ins, input logic [2:0] f);
      return (ins[15:12] == 4'b0000) && ((ins[11:9] & f) != 3'b000);
   endfunction

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {13'd0, flags}, 16'h0002);
      chk("R8", psw, 16'h0002);

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][21:6], VEC[i][5:3]);
         chk((VEC[i][5:3] inside {3'd1, 3'd2, 3'd3}) ? "R2" : "R4", {13'd0, flags}, {13'd0, VEC[i][2:0]});
         chk("R3", {15'd0, $onehot(flags)}, 16'd1);
         chk("R8", psw, {13'd0, VEC[i][2:0]});
      end

      // wr_en low with a flag-writing class: no change (R4)
      @(negedge clk);
      wr_data = 16'h8000; op_class = 3'd1; wr_en = 1'b0;
      @(negedge clk);
      chk("R4", {13'd0, flags}, 16'h0001);
      op_class = 3'd0;

      // every mask against every flag state (R5, R7)
      for (int s = 0; s < 3; s++) begin
         logic [2:0] ef;
         ef = (s == 0) ? 3'b100 : (s == 1) ? 3'b010 : 3'b001;
         wr((s == 0) ? 16'hC000 : (s == 1) ? 16'h0000 : 16'h0042, 3'd1);
         chk("R2", {13'd0, flags}, {13'd0, ef});
         for (int m = 0; m < 8; m++) begin
            instr = {4'b0000, m[2:0], 9'h0A5};
            #1;
            chk((m == 0 || m == 7) ? "R7" : "R5", {15'd0, br_taken}, {15'd0, model_br(instr, ef)});
         end
         // offset field ignored (R9)
         instr = {4'b0000, ef, 9'h000}; #1;
         chk("R9", {15'd0, br_taken}, 16'd1);
         instr = {4'b0000, ef, 9'h1FF}; #1;
         chk("R9", {15'd0, br_taken}, 16'd1);
         instr = {4'b0000, ~ef, 9'h1FF}; #1;
         chk("R9", {15'd0, br_taken}, 16'd0);
         // non-branch opcodes (R6)
         for (int o = 1; o < 16; o++) begin
            instr = {o[3:0], 3'b111, 9'h000}; #1;
            chk("R6", {15'd0, br_taken}, 16'd0);
         end
      end

      // reset mid-run returns to Z (R1)
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk("R1", {13'd0, flags}, 16'h0002);
      instr = 16'h0400; #1;
      chk("R5", {15'd0, br_taken}, 16'd1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule